// File: doc/BRIEF.md
# Programmable Pin Deglitch Filter

This block conditions one asynchronous input pin before the core logic sees it. The raw pin first passes through a synchronizer. A new level is then handed to the core only after the synchronized signal has stayed at that level for a programmable time. The time is the product of a 4-bit count and a power-of-two prescale. A 4-bit select field picks the prescale, from 1 to 32768 base clocks per filter tick. With a 2.5 ns base clock, one short field pair therefore covers times from a few nanoseconds up to about 1.2 ms. The usual setting is count 9 with select 4, which gives roughly 400 ns.

One instance sits on each pin. Its two configuration fields come from that line's configuration word and are read live. Besides the filtered level, the block can give a single-cycle pulse for each change it accepts. Interrupt detection downstream can use that pulse. A count of zero turns the filter off: the synchronized level then goes through with only the register delays.

Top module: `pin_deglitch`

## Requirements
- R1: While `rst_n` is low, `level_o` equals the RESET_LEVEL parameter (default 0) and `change_o` is 0.
- R2: After reset is released, the third rising edge loads `level_o` with the synchronized pin level, whatever the count and select settings are. Before that edge `level_o` keeps its reset value, and this first load raises no `change_o` pulse.
- R3: When `cfg_count` is 0 the filter is bypassed. A pin change reaches `level_o` on the third rising edge counted from the first edge that samples the new pin level. Every change is passed this way, including a pin pulse one cycle long.
- R4: When `cfg_count` = C > 0 and `cfg_sel` = S, the tick period is P = 2^S clocks. A steady new pin level is accepted on the rising edge numbered from C*P+2 to (C+1)*P+1, counting the first sampling edge as edge 0.
- R5: A pin excursion away from `level_o` that lasts C*P clocks or less is never accepted, and `level_o` stays unchanged.
- R6: When the synchronized input returns to the filtered level, all progress is discarded. Two excursions of C*P - 4 clocks each, separated by 2 clocks at the filtered level, produce no change.
- R7: `change_o` is high for exactly the cycles in which `level_o` differs from its value in the previous cycle, after the first load (PULSE_EN = 1).
- R8: The full 4-bit select range is honoured. With S = 10 and C = 3, acceptance falls in the R4 window of 3074 to 4097 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_async | input | 1 | Raw pin level, asynchronous to `clk` |
| cfg_count | input | CNT_W (4) | Number of ticks needed for stability; 0 bypasses the filter |
| cfg_sel | input | SEL_W (4) | Prescale select; a tick every 2^cfg_sel clocks |
| level_o | output | 1 | Filtered pin level |
| change_o | output | 1 | One-cycle pulse marking each accepted change |

## Verification
The pin is driven with steady level changes under four count and select pairs: 1/0, 2/3, the default 9/4, and 3/10. Each accepted change must fall inside the window its pair predicts, which separates a correct tick period and count from an off-by-one or a wrong prescale. Excursions exactly as long as the programmed time, and split excursions with a short return in between, must leave the output unchanged. These tell a real restart apart from a counter that merely pauses or accumulates. Bypass is tried with both a steady change and a one-cycle pulse, and the first load after reset is tried with a long filter setting, so that loading without waiting is seen to differ from filtering.

// File: rtl/deglitch_pkg.sv
package deglitch_pkg;
   // Recommended settings for a line that has not been programmed yet.
   localparam int unsigned DG_DEFAULT_COUNT = 9;
   localparam int unsigned DG_DEFAULT_SEL   = 4;

   // Width of a free-running prescaler able to produce a tick every
   // 2^(2^sel_w - 1) clocks.
   function automatic int unsigned dg_prescale_width(input int unsigned sel_w);
      return (1 << sel_w) - 1;
   endfunction
endpackage

// File: rtl/dg_sync.sv
module dg_sync #(
   parameter int unsigned STAGES    = 2,
   parameter bit          RESET_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic sync_o,
   output logic valid_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("dg_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] shift_q;
   logic [STAGES-1:0] vld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_q <= {STAGES{RESET_VAL}};
         vld_q   <= '0;
      end else begin
         shift_q <= {shift_q[STAGES-2:0], pin_i};
         vld_q   <= {vld_q[STAGES-2:0], 1'b1};
      end
   end

   assign sync_o  = shift_q[STAGES-1];
   assign valid_o = vld_q[STAGES-1];
endmodule

// File: rtl/dg_prescaler.sv
module dg_prescaler
   import deglitch_pkg::*;
#(
   parameter int unsigned SEL_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel_i,
   output logic             tick_o
);
   localparam int unsigned PRE_W = dg_prescale_width(SEL_W);

   if (SEL_W < 1 || SEL_W > 5) begin : g_bad_sel
      $error("dg_prescaler: SEL_W must be between 1 and 5");
   end

   logic [PRE_W-1:0] presc_q;
   logic [PRE_W:0]   mask_wide;
   logic [PRE_W-1:0] mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) presc_q <= '0;
      else        presc_q <= presc_q + 1'b1;
   end

   // Ones in the low sel_i bits: a tick every 2^sel_i clocks.
   assign mask_wide = ({{PRE_W{1'b0}}, 1'b1} << sel_i) - 1'b1;
   assign mask      = mask_wide[PRE_W-1:0];
   assign tick_o    = ((presc_q & mask) == mask);

   p_tick_every_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i == '0) |-> tick_o);
endmodule

// File: rtl/dg_stability.sv
module dg_stability #(
   parameter int unsigned CNT_W       = 4,
   parameter bit          RESET_LEVEL = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_i,
   input  logic             valid_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] count_i,
   output logic             level_o,
   output logic             primed_o
);
   if (CNT_W < 1) begin : g_bad_cnt
      $error("dg_stability: CNT_W must be at least 1");
   end

   logic             level_q;
   logic             primed_q;
   logic [CNT_W-1:0] stab_q;
   logic             differ;
   logic             bypass;

   assign differ = valid_i && (sync_i != level_q);
   assign bypass = (count_i == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q  <= RESET_LEVEL;
         primed_q <= 1'b0;
         stab_q   <= '0;
      end else if (!primed_q) begin
         stab_q <= '0;
         if (valid_i) begin
            level_q  <= sync_i;
            primed_q <= 1'b1;
         end
      end else if (bypass) begin
         level_q <= sync_i;
         stab_q  <= '0;
      end else if (!differ) begin
         stab_q <= '0;
      end else if (tick_i) begin
         if (stab_q >= count_i) begin
            level_q <= sync_i;
            stab_q  <= '0;
         end else begin
            stab_q <= stab_q + 1'b1;
         end
      end
   end

   assign level_o  = level_q;
   assign primed_o = primed_q;

   p_bypass_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (primed_q && bypass) |=> (level_q == $past(sync_i)));

   p_accept_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (primed_q && $past(primed_q) && (level_q != $past(level_q)))
         |-> $past(tick_i || bypass));

   p_hold_between_ticks_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (primed_q && differ && !tick_i && !bypass) |=> $stable(level_q));

   p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!differ) |=> (stab_q == '0));
endmodule

// File: rtl/pin_deglitch.sv
module pin_deglitch #(
   parameter int unsigned CNT_W       = 4,
   parameter int unsigned SEL_W       = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          RESET_LEVEL = 1'b0,
   parameter bit          PULSE_EN    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin_async,
   input  logic [CNT_W-1:0] cfg_count,
   input  logic [SEL_W-1:0] cfg_sel,
   output logic             level_o,
   output logic             change_o
);
   logic sync;
   logic sync_valid;
   logic tick;
   logic primed;

   dg_sync #(
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (RESET_LEVEL)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_i   (pin_async),
      .sync_o  (sync),
      .valid_o (sync_valid)
   );

   dg_prescaler #(
      .SEL_W (SEL_W)
   ) u_presc (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel_i  (cfg_sel),
      .tick_o (tick)
   );

   dg_stability #(
      .CNT_W       (CNT_W),
      .RESET_LEVEL (RESET_LEVEL)
   ) u_stab (
      .clk      (clk),
      .rst_n    (rst_n),
      .sync_i   (sync),
      .valid_i  (sync_valid),
      .tick_i   (tick),
      .count_i  (cfg_count),
      .level_o  (level_o),
      .primed_o (primed)
   );

   if (PULSE_EN) begin : g_pulse
      logic lvl_prev_q;
      logic primed_prev_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lvl_prev_q    <= RESET_LEVEL;
            primed_prev_q <= 1'b0;
         end else begin
            lvl_prev_q    <= level_o;
            primed_prev_q <= primed;
         end
      end

      assign change_o = primed_prev_q && (level_o != lvl_prev_q);

      p_pulse_marks_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
         change_o |-> (level_o != $past(level_o)));
   end else begin : g_no_pulse
      assign change_o = 1'b0;
   end

   p_reset_state_r1: assert property (@(posedge clk)
      !rst_n |=> (level_o == RESET_LEVEL));
endmodule

// File: tb/pin_deglitch_test.sv
module pin_deglitch_test;
   import deglitch_pkg::*;

   typedef struct {
      bit    lvl;
      int    lo;
      int    hi;
      string req;
   } exp_item_t;

   logic       clk   = 1'b0;
   logic       rst_n = 1'b0;
   logic       pin   = 1'b1;
   logic [3:0] cnt   = 4'(DG_DEFAULT_COUNT);
   logic [3:0] sel   = 4'(DG_DEFAULT_SEL);
   logic       level;
   logic       chg;

   int  cyc = 0;
   int  n_checks = 0;
   int  n_fail = 0;
   bit  done = 1'b0;
   bit  exp_lvl = 1'b0;
   bit  mon_on = 1'b0;
   exp_item_t sb_q[$];

   pin_deglitch uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_async (pin),
      .cfg_count (cnt),
      .cfg_sel   (sel),
      .level_o   (level),
      .change_o  (chg)
   );

   always #10 clk = ~clk;

   always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Driver: change the pin at a falling edge and queue the expected change.
   task automatic drive_expect(input bit v, input string req);
      exp_item_t it;
      int p;
      p = 1 << sel;
      pin = v;
      it.lvl = v;
      it.req = req;
      if (cnt == 0) begin
         it.lo = cyc + 3;
         it.hi = cyc + 3;
      end else begin
         it.lo = cyc + 3 + int'(cnt) * p;
         it.hi = cyc + 2 + (int'(cnt) + 1) * p;
      end
      exp_lvl = v;
      sb_q.push_back(it);
   endtask

   task automatic settle();
      int last;
      last = cyc;
      foreach (sb_q[i]) if (sb_q[i].hi > last) last = sb_q[i].hi;
      wait_cyc(last - cyc + 4);
   endtask

   // Monitor: pop an expected item for every accepted change.
   always @(negedge clk) begin
      if (mon_on && rst_n && chg) begin
         if (sb_q.size() == 0) begin
            check(1'b0, "R7", "unexpected change pulse, level", int'(level), int'(exp_lvl));
         end else begin
            exp_item_t it;
            it = sb_q.pop_front();
            check(level == it.lvl, it.req, "accepted level", int'(level), int'(it.lvl));
            check(cyc >= it.lo && cyc <= it.hi, it.req, "accept edge (window low bound)",
                  cyc, it.lo);
         end
      end
   end

   initial begin
      #(200000 * 20);
      check(1'b0, "R4", "watchdog expired, cycle", cyc, 200000);
      finish_run();
   end

   initial begin
      // R1: reset state
      wait_cyc(3);
      check(level == 1'b0, "R1", "level in reset", int'(level), 0);
      check(chg == 1'b0, "R1", "change in reset", int'(chg), 0);
      rst_n = 1'b1;
      mon_on = 1'b1;

      // R2: first load after exactly three edges, no pulse
      wait_cyc(2);
      check(level == 1'b0, "R2", "level before first load", int'(level), 0);
      wait_cyc(1);
      check(level == 1'b1, "R2", "level after first load", int'(level), 1);
      check(chg == 1'b0, "R2", "no pulse on first load", int'(chg), 0);
      exp_lvl = 1'b1;
      wait_cyc(4);

      // R4: default setting, count 9, select 4
      drive_expect(1'b0, "R4");
      settle();

      // R4: count 1, select 0
      cnt = 4'd1; sel = 4'd0;
      wait_cyc(2);
      drive_expect(1'b1, "R4");
      settle();

      // R4: count 2, select 3
      cnt = 4'd2; sel = 4'd3;
      wait_cyc(2);
      drive_expect(1'b0, "R4");
      settle();

      // R5: excursion exactly count*P long is rejected (count 3, select 2)
      cnt = 4'd3; sel = 4'd2;
      wait_cyc(2);
      pin = 1'b1;
      wait_cyc(12);
      pin = 1'b0;
      wait_cyc(20);
      check(level == 1'b0, "R5", "level after short excursion", int'(level), 0);

      // R6: two split excursions do not accumulate
      pin = 1'b1;
      wait_cyc(8);
      pin = 1'b0;
      wait_cyc(2);
      pin = 1'b1;
      wait_cyc(8);
      pin = 1'b0;
      wait_cyc(20);
      check(level == 1'b0, "R6", "level after split excursions", int'(level), 0);

      // R4: the same setting accepts a steady change
      drive_expect(1'b1, "R4");
      settle();

      // R3: bypass, steady change then a one-cycle pulse
      cnt = 4'd0;
      wait_cyc(2);
      drive_expect(1'b0, "R3");
      settle();
      drive_expect(1'b1, "R3");
      wait_cyc(1);
      drive_expect(1'b0, "R3");
      settle();

      // R8: wide prescale, count 3, select 10
      cnt = 4'd3; sel = 4'd10;
      wait_cyc(2);
      drive_expect(1'b1, "R8");
      settle();

      check(sb_q.size() == 0, "R7", "pending expected changes", sb_q.size(), 0);
      check(level == 1'b1, "R8", "final level", int'(level), 1);
      finish_run();
   end
endmodule